// File: doc/BRIEF.md
# Minicomputer Major-State Cycle Timer

This block models how long a 12-bit single-accumulator minicomputer spends on one instruction in core memory. A producer hands it one instruction word, along with the address of the indirect pointer that the word refers to. The block then walks through the major states that the instruction needs. Fetch always occurs. Defer occurs only for an indirect memory reference. Execute occurs only for the opcodes that touch an operand.

Each major state occupies one memory cycle, either short (1200 ns) or long (1400 ns). A memory cycle is timed by counting clock ticks, and the tick count is derived from the clock-period parameter. While the instruction runs, the block shows which state is active and whether the current cycle is long. When the instruction ends, the block pulses `done_o` and presents the instruction's total time in nanoseconds.

The input side is a valid/ready handshake. `in_ready` is high only while the block is idle. A word presented while `in_ready` is low is not taken, and the producer must keep `in_valid`, `in_instr` and `in_ptr` steady until a clock edge sees both `in_valid` and `in_ready` high. The outputs are plain status pins with no back-pressure.

Top module: `mcyc_timer`

## Requirements
- R1: `in_ready` is 1 exactly when `state_o` is idle (code 0). A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_valid` and the data presented while `in_ready` is 0 have no effect on the running instruction's timing, trace or total.
- R2: The opcode is `in_instr[11:9]`: 0 AND, 1 TAD, 2 ISZ, 3 DCA, 4 JMS, 5 JMP, 6 IOT, 7 OPR. Bit 8 requests indirect addressing. `in_instr` and `in_ptr` are captured at acceptance.
- R3: The first major state of every instruction is fetch (`state_o` = 1). Fetch is a short cycle and begins on the clock edge that accepts the word.
- R4: For opcodes 0 to 5 with bit 8 set, a defer state (`state_o` = 2) follows fetch. Defer is long when `in_ptr` lies in 8 to 15 (octal 0010 to 0017) and short otherwise.
- R5: Opcodes 0 to 4 end with one long execute state (`state_o` = 3). Opcode 5 has no execute state.
- R6: Opcodes 6 and 7 use only the fetch cycle, whatever the value of bit 8.
- R7: A short cycle lasts SHORT_NS/CLK_NS clock periods and a long cycle lasts LONG_NS/CLK_NS. `cyc_long_o` is 1 throughout a long cycle and 0 during short cycles and while idle.
- R8: On the clock edge that ends the last major state, `state_o` returns to 0 and `done_o` is high for exactly one cycle. At that point `total_ns_o` equals the sum of 1200 for each short cycle and 1400 for each long cycle of the instruction. The total then holds until the next acceptance.
- R9: After reset, `state_o` is 0, `in_ready` is 1, and `done_o`, `cyc_long_o` and `total_ns_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_instr | input | 12 | Instruction word |
| in_ptr | input | 12 | Address of the indirect pointer |
| state_o | output | 2 | Major state: 0 idle, 1 fetch, 2 defer, 3 execute |
| cyc_long_o | output | 1 | Current memory cycle is long |
| done_o | output | 1 | One-cycle pulse at the end of the instruction |
| total_ns_o | output | 16 | Elapsed time of the last instruction in ns |

## Verification
The bench builds the block with CLK_NS set to 20, which matches its 50 MHz clock. That gives 60-tick short cycles and 70-tick long cycles. The 10-tick gap lets a trace taken on every clock cycle catch any state that ends one tick too early or too late, and an instruction with all three states still finishes in about 200 cycles. Every opcode is run with direct, plain indirect and autoindexed pointers, including the pointer edges 7, 8, 15 and 16. Random words and junk offers made while the block is busy are mixed in.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DEFER = 2'd2,
    ST_EXEC  = 2'd3
  } mstate_e;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_TAD = 3'd1,
    OP_ISZ = 3'd2,
    OP_DCA = 3'd3,
    OP_JMS = 3'd4,
    OP_JMP = 3'd5,
    OP_IOT = 3'd6,
    OP_OPR = 3'd7
  } opc_e;

endpackage

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
#(
  parameter int AW      = 12,
  parameter int AUTO_LO = 8,
  parameter int AUTO_HI = 15
) (
  input  logic [2:0]    opc,
  input  logic          ind,
  input  logic [AW-1:0] ptr,
  output logic          need_defer,
  output logic          defer_long,
  output logic          need_exec
);

  localparam logic [AW-1:0] LO_A = AW'(AUTO_LO);
  localparam logic [AW-1:0] HI_A = AW'(AUTO_HI);

  opc_e op;
  logic mem_ref;
  logic auto_ptr;

  assign op = opc_e'(opc);

  always_comb begin
    mem_ref   = 1'b0;
    need_exec = 1'b0;
    case (op)
      OP_AND, OP_TAD, OP_ISZ, OP_DCA, OP_JMS: begin
        mem_ref   = 1'b1;
        need_exec = 1'b1;
      end
      OP_JMP:  mem_ref = 1'b1;
      default: mem_ref = 1'b0;
    endcase
  end

  assign auto_ptr   = (ptr >= LO_A) && (ptr <= HI_A);
  assign need_defer = mem_ref && ind;
  assign defer_long = auto_ptr;

endmodule

// File: rtl/mcyc_tick.sv
module mcyc_tick #(
  parameter int SHORT_T = 12,
  parameter int LONG_T  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_long,
  output logic zero
);

  localparam int CW = $clog2(LONG_T + 1);
  localparam logic [CW-1:0] S_LAST = CW'(SHORT_T - 1);
  localparam logic [CW-1:0] L_LAST = CW'(LONG_T - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_long ? L_LAST : S_LAST;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= L_LAST);

  assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick_zero,
  input  logic       need_defer,
  input  logic       defer_long,
  input  logic       need_exec,
  output logic [1:0] state_o,
  output logic       cyc_long_o,
  output logic       load_o,
  output logic       load_long_o,
  output logic       end_cyc_o,
  output logic       done_o
);

  mstate_e st_q, st_d, after;
  logic    busy;
  logic    done_q;

  function automatic logic is_long(mstate_e s, logic dl);
    case (s)
      ST_DEFER: return dl;
      ST_EXEC:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  assign busy = (st_q != ST_IDLE);

  always_comb begin
    case (st_q)
      ST_FETCH: after = need_defer ? ST_DEFER : (need_exec ? ST_EXEC : ST_IDLE);
      ST_DEFER: after = need_exec ? ST_EXEC : ST_IDLE;
      default:  after = ST_IDLE;
    endcase
    st_d   = st_q;
    load_o = 1'b0;
    if (!busy) begin
      if (start) begin
        st_d   = ST_FETCH;
        load_o = 1'b1;
      end
    end else if (tick_zero) begin
      st_d   = after;
      load_o = (after != ST_IDLE);
    end
  end

  assign load_long_o = is_long(st_d, defer_long);
  assign end_cyc_o   = busy && tick_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= end_cyc_o && (after == ST_IDLE);
    end
  end

  assign state_o    = st_q;
  assign cyc_long_o = is_long(st_q, defer_long);
  assign done_o     = done_q;

  assert_fetch_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (state_o == 2'd1 && !cyc_long_o));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_o == 2'd0 && $past(state_o) != 2'd0));

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_zero) |=> $stable(state_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/mcyc_timer.sv
module mcyc_timer
  import mcyc_pkg::*;
#(
  parameter int CLK_NS   = 100,
  parameter int SHORT_NS = 1200,
  parameter int LONG_NS  = 1400,
  parameter int IW       = 12,
  parameter int AW       = 12,
  parameter int TW       = 16,
  parameter int AUTO_LO  = 8,
  parameter int AUTO_HI  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_instr,
  input  logic [AW-1:0] in_ptr,
  output logic [1:0]    state_o,
  output logic          cyc_long_o,
  output logic          done_o,
  output logic [TW-1:0] total_ns_o
);

  localparam int SHORT_T = SHORT_NS / CLK_NS;
  localparam int LONG_T  = LONG_NS / CLK_NS;
  localparam logic [TW-1:0] S_NS = TW'(SHORT_NS);
  localparam logic [TW-1:0] L_NS = TW'(LONG_NS);

  logic [IW-1:0] instr_q;
  logic [AW-1:0] ptr_q;
  logic [TW-1:0] total_q;
  logic start, tick_zero, need_defer, defer_long, need_exec;
  logic load, load_long, end_cyc;

  assign in_ready = (state_o == 2'd0);
  assign start    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr_q <= '0;
      ptr_q   <= '0;
      total_q <= '0;
    end else if (start) begin
      instr_q <= in_instr;
      ptr_q   <= in_ptr;
      total_q <= '0;
    end else if (end_cyc) begin
      total_q <= total_q + (cyc_long_o ? L_NS : S_NS);
    end
  end

  assign total_ns_o = total_q;

  mcyc_decode #(.AW(AW), .AUTO_LO(AUTO_LO), .AUTO_HI(AUTO_HI)) u_dec (
    .opc        (instr_q[IW-1 -: 3]),
    .ind        (instr_q[IW-4]),
    .ptr        (ptr_q),
    .need_defer (need_defer),
    .defer_long (defer_long),
    .need_exec  (need_exec)
  );

  mcyc_tick #(.SHORT_T(SHORT_T), .LONG_T(LONG_T)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_long (load_long),
    .zero      (tick_zero)
  );

  mcyc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .tick_zero   (tick_zero),
    .need_defer  (need_defer),
    .defer_long  (defer_long),
    .need_exec   (need_exec),
    .state_o     (state_o),
    .cyc_long_o  (cyc_long_o),
    .load_o      (load),
    .load_long_o (load_long),
    .end_cyc_o   (end_cyc),
    .done_o      (done_o)
  );

  assert_exec_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |-> cyc_long_o);

  assert_defer_auto_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && cyc_long_o) |-> (ptr_q >= AW'(AUTO_LO) && ptr_q <= AW'(AUTO_HI)));

  assert_no_defer_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> (instr_q[IW-1 -: 2] != 2'b11));

  assert_done_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (total_ns_o >= S_NS));

  assert_word_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |=> $stable(instr_q));

  assert_total_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !in_valid) |=> $stable(total_ns_o));

endmodule

// File: tb/sim_mcyc_timer.sv
module sim_mcyc_timer;

  localparam int CLK_NS = 20;
  localparam int ST = 1200 / CLK_NS;
  localparam int LT = 1400 / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_instr = '0;
  logic [11:0] in_ptr = '0;
  logic [1:0]  state_o;
  logic        cyc_long_o;
  logic        done_o;
  logic [15:0] total_ns_o;

  int n_chk = 0;
  int n_bad = 0;
  int seed_sink;

  always #10 clk = ~clk;

  mcyc_timer #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_ptr(in_ptr), .state_o(state_o),
    .cyc_long_o(cyc_long_o), .done_o(done_o), .total_ns_o(total_ns_o)
  );

  function automatic int defer_ticks(logic [11:0] w, logic [11:0] p);
    if (w[11:9] < 3'd6 && w[8]) return (p >= 12'd8 && p <= 12'd15) ? LT : ST;
    return 0;
  endfunction

  function automatic int exec_ticks(logic [11:0] w);
    return (w[11:9] < 3'd5) ? LT : 0;
  endfunction

  function automatic int exp_ns(logic [11:0] w, logic [11:0] p);
    int d = defer_ticks(w, p);
    int e = exec_ticks(w);
    return 1200 + (d == LT ? 1400 : (d == ST ? 1200 : 0)) + (e != 0 ? 1400 : 0);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Runs one word and checks the full per-cycle trace (R1,R3,R4,R5,R6,R7,R8).
  task automatic run(input logic [11:0] w, input logic [11:0] p, input bit junk);
    int d = defer_ticks(w, p);
    int e = exec_ticks(w);
    int tot = ST + d + e;
    int k = 0;
    int bad = 0;
    int first_k = -1;
    int exp_st;
    logic exp_lg;
    logic [15:0] held;
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_ptr = p;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (1) begin
      if (k < ST) begin exp_st = 1; exp_lg = 1'b0; end
      else if (k < ST + d) begin exp_st = 2; exp_lg = (d == LT); end
      else if (k < tot) begin exp_st = 3; exp_lg = 1'b1; end
      else begin exp_st = 0; exp_lg = 1'b0; end
      if (state_o != 2'(exp_st) || cyc_long_o != exp_lg ||
          in_ready != (exp_st == 0) || done_o != (k == tot)) begin
        bad++;
        if (first_k < 0) first_k = k;
      end
      if (k >= tot) break;
      if (junk) begin
        in_valid = $urandom_range(0, 1);
        in_instr = 12'($urandom);
        in_ptr = 12'($urandom);
      end
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(bad == 0, $sformatf("R3/R4/R5/R6/R7 trace w=%o p=%o first bad tick", w, p),
          first_k, -1);
    check(total_ns_o == 16'(exp_ns(w, p)), $sformatf("R8 total w=%o p=%o", w, p),
          total_ns_o, exp_ns(w, p));
    held = total_ns_o;
    @(negedge clk);
    check(total_ns_o == held && !done_o && in_ready, "R8 hold after done R1 ready",
          total_ns_o, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(state_o == 2'd0 && in_ready && !done_o && !cyc_long_o && total_ns_o == 16'd0,
          "R9 reset state", int'(state_o), 0);

    // R2/R6: every opcode, direct, indirect plain, indirect autoindex
    for (int op = 0; op < 8; op++) begin
      run({3'(op), 1'b0, 8'o35}, 12'o0200, 1'b0);
      run({3'(op), 1'b1, 8'o35}, 12'o0200, 1'b0);
      run({3'(op), 1'b1, 8'o12}, 12'o0012, 1'b1);
    end
    // R4 pointer edges
    run(12'o1400, 12'd7, 1'b0);
    run(12'o1400, 12'd8, 1'b0);
    run(12'o5400, 12'd15, 1'b0);
    run(12'o5400, 12'd16, 1'b0);
    // R6 bit 8 ignored with an autoindex pointer
    run(12'o7777, 12'd9, 1'b1);
    run(12'o6777, 12'd10, 1'b1);
    // R1: offers while busy are ignored
    for (int i = 0; i < 6; i++) run(12'o2400, 12'o0013, 1'b1);
    // random mix
    for (int i = 0; i < 40; i++)
      run(12'($urandom), ($urandom_range(0, 3) == 0) ? 12'($urandom_range(6, 17)) : 12'($urandom),
          1'($urandom_range(0, 1)));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule